// File: doc/BRIEF.md
# Region-Partitioned Virtual Address Translator

This block turns a 32-bit virtual address into a physical address. It walks page tables that are split by address region. The two top bits of the address choose among three regions:

- a system region;
- a user region that grows upward from page zero;
- a user region that grows downward from the top page.

The fourth encoding is reserved. Each user region has a base and a length. The system region has only a base. A user page table does not sit in physical memory. It sits in system virtual space, so a user lookup first translates the address of its own table entry through the system table, and only then reads the user entry.

Only one translation runs at a time. The CPU side raises `req_valid` while `req_ready` is high. The block answers with a one-cycle `done` pulse. The pulse carries either the physical address or a fault code:

- 0: no fault;
- 1: length or access violation;
- 2: entry not valid.

Table entries are fetched through a single read port. The port holds `mem_rd` until `mem_rvalid` returns. When paging is switched off, the address passes straight through, and its two top bits are dropped.

The controller has four states:

- `ST_IDLE`: waits for a request.
- `ST_SYS_PTE_READ`: reads a system entry.
- `ST_USER_PTE_READ`: reads a user entry.
- `ST_DONE`: presents the result for one cycle.

Its transitions are:

- **IDLE→DONE**: paging is off, or the length check fails.
- **IDLE→SYS_PTE_READ**: a system or user lookup starts.
- **SYS_PTE_READ→USER_PTE_READ**: a nested user lookup found a valid system entry.
- **SYS_PTE_READ→DONE**: the lookup is a plain system lookup, or the system entry is invalid.
- **USER_PTE_READ→DONE**: the user entry has been read.
- **DONE→IDLE**: always, after one cycle.

Top module: `region_xlate`

## Requirements
- R1: Out of reset, `req_ready` is 1 and both `done` and `mem_rd` are 0.
- R2: With `paging_en` low, an accepted request gives `done` on the next cycle. It returns `done_paddr` = vaddr[29:0] with fault 0 and makes no memory read.
- R3: With paging on, region bits [31:30] = 11 give fault 1 on the next cycle with `done_paddr` = 0 and no memory read.
- R4: Region 10 (system) reads one entry at `sys_base` + 4·vpn, where vpn = vaddr[29:9]. No length check applies to any vpn. The result is {entry[20:0], vaddr[8:0]}.
- R5: Region 00 (upward user region) accepts a vpn only when vpn < `up_len`. Otherwise it gives fault 1 on the next cycle with no read.
- R6: Region 01 (downward user region) accepts a vpn only when vpn ≥ `down_len`, so the vpn equal to `down_len` is valid. Otherwise it gives fault 1 on the next cycle with no read.
- R7: For a user region, the table-entry virtual address is T = base + 4·vpn, taken modulo 2^32. The block first reads `sys_base` + 4·T[29:9]. It then reads {that entry[20:0], T[8:0]}. The result is {second entry[20:0], vaddr[8:0]}.
- R8: An entry whose bit 31 is 0 ends the walk with fault 2 and `done_paddr` = 0. When this happens on the first read of a user lookup, no second read is made.
- R9: `done` lasts exactly one cycle. It comes 1 + reads·(memory latency + 1) cycles after acceptance. Requests raised while `req_ready` is low are ignored and leave the running result unchanged.
- R10: `mem_rd` stays high and `mem_addr` stays stable from the start of each read until the cycle `mem_rvalid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| paging_en | input | 1 | Enables translation; when low the address passes straight through |
| sys_base | input | 30 | Physical address of the system page table |
| up_base | input | 32 | System-virtual base of the upward user table |
| up_len | input | 21 | Page count of the upward user region |
| down_base | input | 32 | System-virtual base of the downward user table |
| down_len | input | 21 | Lowest valid page of the downward user region |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_ready | output | 1 | Block idle and able to accept a request |
| done | output | 1 | One-cycle result pulse |
| done_paddr | output | 30 | Physical address (0 on a fault) |
| done_fault | output | 2 | 0 none, 1 length/access, 2 entry not valid |
| mem_rd | output | 1 | Table-entry read request |
| mem_addr | output | 30 | Physical address of the entry being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table entry: bit 31 valid, bits [20:0] frame number |

## Verification
The bench builds the block with its default widths: 32-bit virtual addresses, 9-bit page offsets and 21-bit frame numbers. Because the page-number field is full size, the largest system page number and the downward region's boundary just below 2^21 can both be reached.

The bench's memory answers after one wait cycle. This exercises the hold of the read request, and the nested two-read walk takes a measurable number of cycles. Table entries are derived from their address by a formula, so any table location can be reached without preloading. Chosen locations are then marked invalid to cover both the first-read and the second-read fault paths.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [1:0] {
        ST_IDLE          = 2'd0,
        ST_SYS_PTE_READ  = 2'd1,
        ST_USER_PTE_READ = 2'd2,
        ST_DONE          = 2'd3
    } xlate_state_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'd0,
        FLT_LENGTH  = 2'd1,
        FLT_INVALID = 2'd2
    } xlate_fault_e;

    typedef enum logic [1:0] {
        RGN_UP   = 2'b00,
        RGN_DOWN = 2'b01,
        RGN_SYS  = 2'b10,
        RGN_RSVD = 2'b11
    } xlate_region_e;

endpackage

// File: rtl/xlate_region_check.sv
module xlate_region_check
    import xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 9,
    localparam int VPN_W = VA_W - 2 - OFF_W
) (
    input  logic [VA_W-1:0]  vaddr_i,
    input  logic [VPN_W-1:0] up_len_i,
    input  logic [VPN_W-1:0] down_len_i,
    output xlate_region_e    region_o,
    output logic [VPN_W-1:0] vpn_o,
    output logic             len_ok_o
);
    always_comb begin
        region_o = xlate_region_e'(vaddr_i[VA_W-1 -: 2]);
        vpn_o    = vaddr_i[VA_W-3:OFF_W];
        unique case (region_o)
            RGN_UP:   len_ok_o = (vpn_o < up_len_i);
            RGN_DOWN: len_ok_o = (vpn_o >= down_len_i);
            RGN_SYS:  len_ok_o = 1'b1;
            RGN_RSVD: len_ok_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/xlate_pte_addr.sv
module xlate_pte_addr
    import xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 9,
    parameter int PFN_W = 21,
    localparam int VPN_W = VA_W - 2 - OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  xlate_region_e    region_i,
    input  logic [VPN_W-1:0] vpn_i,
    input  logic [PA_W-1:0]  sys_base_i,
    input  logic [VA_W-1:0]  up_base_i,
    input  logic [VA_W-1:0]  down_base_i,
    output logic [PA_W-1:0]  sys_pte_pa_o,
    output logic [VA_W-1:0]  user_pte_va_o,
    output logic [PA_W-1:0]  nest_pte_pa_o
);
    localparam int ENTRY_SH = 2;

    logic [VA_W-1:0]  user_base;
    logic [VPN_W-1:0] nest_vpn;

    always_comb begin
        user_base     = (region_i == RGN_DOWN) ? down_base_i : up_base_i;
        sys_pte_pa_o  = sys_base_i + PA_W'({vpn_i, {ENTRY_SH{1'b0}}});
        user_pte_va_o = user_base + VA_W'({vpn_i, {ENTRY_SH{1'b0}}});
        nest_vpn      = user_pte_va_o[VA_W-3:OFF_W];
        nest_pte_pa_o = sys_base_i + PA_W'({nest_vpn, {ENTRY_SH{1'b0}}});
    end
endmodule

// File: rtl/region_xlate.sv
module region_xlate
    import xlate_pkg::*;
#(
    parameter int VA_W  = 32,
    parameter int OFF_W = 9,
    parameter int PFN_W = 21,
    parameter int PTE_W = 32,
    localparam int VPN_W = VA_W - 2 - OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             paging_en,
    input  logic [PA_W-1:0]  sys_base,
    input  logic [VA_W-1:0]  up_base,
    input  logic [VPN_W-1:0] up_len,
    input  logic [VA_W-1:0]  down_base,
    input  logic [VPN_W-1:0] down_len,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    output logic             req_ready,
    output logic             done,
    output logic [PA_W-1:0]  done_paddr,
    output logic [1:0]       done_fault,
    output logic             mem_rd,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [PTE_W-1:0] mem_rdata
);
    localparam int VALID_BIT = PTE_W - 1;

    xlate_state_e    state_q;
    xlate_fault_e    fault_q;
    logic [VA_W-1:0] va_q;
    logic [VA_W-1:0] pte_va_q;
    logic [PA_W-1:0] addr_q;
    logic [PA_W-1:0] paddr_q;
    logic            nested_q;

    xlate_region_e    region;
    logic [VPN_W-1:0] vpn;
    logic             len_ok;
    logic [PA_W-1:0]  sys_pte_pa;
    logic [VA_W-1:0]  user_pte_va;
    logic [PA_W-1:0]  nest_pte_pa;
    logic             pte_ok;
    logic [PFN_W-1:0] pte_pfn;
    logic             accept;

    xlate_region_check #(.VA_W(VA_W), .OFF_W(OFF_W)) u_region (
        .vaddr_i    (req_vaddr),
        .up_len_i   (up_len),
        .down_len_i (down_len),
        .region_o   (region),
        .vpn_o      (vpn),
        .len_ok_o   (len_ok)
    );

    xlate_pte_addr #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_addr (
        .region_i      (region),
        .vpn_i         (vpn),
        .sys_base_i    (sys_base),
        .up_base_i     (up_base),
        .down_base_i   (down_base),
        .sys_pte_pa_o  (sys_pte_pa),
        .user_pte_va_o (user_pte_va),
        .nest_pte_pa_o (nest_pte_pa)
    );

    assign pte_ok  = mem_rdata[VALID_BIT];
    assign pte_pfn = mem_rdata[PFN_W-1:0];
    assign accept  = req_valid && (state_q == ST_IDLE);

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            fault_q  <= FLT_NONE;
            va_q     <= '0;
            pte_va_q <= '0;
            addr_q   <= '0;
            paddr_q  <= '0;
            nested_q <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        va_q    <= req_vaddr;
                        fault_q <= FLT_NONE;
                        paddr_q <= '0;
                        if (!paging_en) begin
                            paddr_q <= req_vaddr[PA_W-1:0];
                            state_q <= ST_DONE;
                        end else if (!len_ok) begin
                            fault_q <= FLT_LENGTH;
                            state_q <= ST_DONE;
                        end else if (region == RGN_SYS) begin
                            addr_q   <= sys_pte_pa;
                            nested_q <= 1'b0;
                            state_q  <= ST_SYS_PTE_READ;
                        end else begin
                            pte_va_q <= user_pte_va;
                            addr_q   <= nest_pte_pa;
                            nested_q <= 1'b1;
                            state_q  <= ST_SYS_PTE_READ;
                        end
                    end
                end
                ST_SYS_PTE_READ: begin
                    if (mem_rvalid) begin
                        if (!pte_ok) begin
                            fault_q <= FLT_INVALID;
                            state_q <= ST_DONE;
                        end else if (nested_q) begin
                            addr_q  <= {pte_pfn, pte_va_q[OFF_W-1:0]};
                            state_q <= ST_USER_PTE_READ;
                        end else begin
                            paddr_q <= {pte_pfn, va_q[OFF_W-1:0]};
                            state_q <= ST_DONE;
                        end
                    end
                end
                ST_USER_PTE_READ: begin
                    if (mem_rvalid) begin
                        if (!pte_ok) begin
                            fault_q <= FLT_INVALID;
                        end else begin
                            paddr_q <= {pte_pfn, va_q[OFF_W-1:0]};
                        end
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready  = 1'b0;
        done       = 1'b0;
        mem_rd     = 1'b0;
        mem_addr   = addr_q;
        done_paddr = paddr_q;
        done_fault = fault_q;
        unique case (state_q)
            ST_IDLE:          req_ready = 1'b1;
            ST_SYS_PTE_READ:  mem_rd    = 1'b1;
            ST_USER_PTE_READ: mem_rd    = 1'b1;
            ST_DONE:          done      = 1'b1;
        endcase
    end
endmodule

// File: rtl/region_xlate_chk.sv
module region_xlate_chk #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 9,
    parameter int PFN_W = 21,
    localparam int VPN_W = VA_W - 2 - OFF_W,
    localparam int PA_W  = PFN_W + OFF_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             paging_en,
    input logic [VPN_W-1:0] up_len,
    input logic [VPN_W-1:0] down_len,
    input logic             req_valid,
    input logic [VA_W-1:0]  req_vaddr,
    input logic             req_ready,
    input logic             done,
    input logic [PA_W-1:0]  done_paddr,
    input logic [1:0]       done_fault,
    input logic             mem_rd,
    input logic [PA_W-1:0]  mem_addr,
    input logic             mem_rvalid
);
    logic             acc;
    logic [1:0]       rgn;
    logic [VPN_W-1:0] pg;

    assign acc = req_valid && req_ready;
    assign rgn = req_vaddr[VA_W-1 -: 2];
    assign pg  = req_vaddr[VA_W-3:OFF_W];

    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        acc && !paging_en |=> done && done_fault == 2'd0 && done_paddr == $past(req_vaddr[PA_W-1:0])); // R2
    AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && paging_en && rgn == 2'b11 |=> done && done_fault == 2'd1 && !mem_rd); // R3
    AST_UP_LEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && paging_en && rgn == 2'b00 && pg >= up_len |=> done && done_fault == 2'd1); // R5
    AST_DOWN_LEN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        acc && paging_en && rgn == 2'b01 && pg < down_len |=> done && done_fault == 2'd1); // R6
    AST_FAULT_ZERO_PA: assert property (@(posedge clk) disable iff (!rst_n)
        done && done_fault != 2'd0 |-> done_paddr == '0); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || done) |-> !req_ready); // R9
    AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !mem_rvalid |=> mem_rd && $stable(mem_addr)); // R10
endmodule

bind region_xlate region_xlate_chk #(.VA_W(VA_W), .OFF_W(OFF_W), .PFN_W(PFN_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .paging_en  (paging_en),
    .up_len     (up_len),
    .down_len   (down_len),
    .req_valid  (req_valid),
    .req_vaddr  (req_vaddr),
    .req_ready  (req_ready),
    .done       (done),
    .done_paddr (done_paddr),
    .done_fault (done_fault),
    .mem_rd     (mem_rd),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid)
);

// File: tb/test_region_xlate.sv
module test_region_xlate;
    localparam int LAT = 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic [29:0] sys_base = 30'h0001_0000;
    logic [31:0] up_base = 32'h8000_4000;
    logic [20:0] up_len = 21'd8;
    logic [31:0] down_base = 32'h8000_6000;
    logic [20:0] down_len = 21'h1FFFF0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_ready, done, mem_rd;
    logic [29:0] done_paddr, mem_addr;
    logic [1:0]  done_fault;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    int lat_cnt = 0;
    logic [29:0] got_addr[$];
    logic [29:0] held_addr;
    bit          bad_entry[int unsigned];

    always #2.5 clk = ~clk;

    region_xlate i_region_xlate (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .sys_base(sys_base),
        .up_base(up_base), .up_len(up_len), .down_base(down_base), .down_len(down_len),
        .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
        .done(done), .done_paddr(done_paddr), .done_fault(done_fault),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Table entries come from a formula over the address, minus a set marked bad
    function automatic logic [31:0] pte_of(input logic [29:0] a);
        logic [20:0] pfn;
        pfn = 21'((int'(a) * 7 + 3) & 32'h1F_FFFF);
        if (bad_entry.exists(int'(a))) return {1'b0, 10'd0, pfn};
        return {1'b1, 10'd0, pfn};
    endfunction

    // Behavioural reference: result, fault and the list of addresses it reads
    task automatic model(input logic [31:0] va, output logic [29:0] pa,
                         output logic [1:0] flt, output logic [29:0] rd[$]);
        int unsigned vpn, off, rg, tva, a, e;
        vpn = (va >> 9) & 32'h1F_FFFF;
        off = va & 32'h1FF;
        rg  = va >> 30;
        pa = '0; flt = 2'd0; rd = {};
        if (!paging_en) begin pa = va[29:0]; return; end
        if (rg == 3 || (rg == 0 && vpn >= up_len) || (rg == 1 && vpn < down_len)) begin
            flt = 2'd1; return;
        end
        if (rg == 2) begin
            a = (sys_base + vpn * 4) & 32'h3FFF_FFFF;
            rd.push_back(30'(a));
            e = pte_of(30'(a));
        end else begin
            tva = ((rg == 0) ? up_base : down_base) + vpn * 4;
            a = (sys_base + ((tva >> 9) & 32'h1F_FFFF) * 4) & 32'h3FFF_FFFF;
            rd.push_back(30'(a));
            e = pte_of(30'(a));
            if (e[31] == 1'b0) begin flt = 2'd2; return; end
            a = ((e & 32'h1F_FFFF) * 512 + (tva & 32'h1FF)) & 32'h3FFF_FFFF;
            rd.push_back(30'(a));
            e = pte_of(30'(a));
        end
        if (e[31] == 1'b0) begin flt = 2'd2; return; end
        pa = 30'((e & 32'h1F_FFFF) * 512 + off);
    endtask

    // Memory responder with LAT wait cycles; checks the read is held (R10)
    always @(negedge clk) begin
        if (!rst_n || !mem_rd) begin
            mem_rvalid = 1'b0;
            lat_cnt = 0;
        end else begin
            if (lat_cnt == 0 && !mem_rvalid) held_addr = mem_addr;
            else if (mem_rvalid) held_addr = mem_addr;
            else chk(mem_addr == held_addr, "R10", "mem_addr held", mem_addr, held_addr);
            if (lat_cnt == LAT) begin
                mem_rvalid = 1'b1;
                mem_rdata = pte_of(mem_addr);
                got_addr.push_back(mem_addr);
                lat_cnt = 0;
            end else begin
                mem_rvalid = 1'b0;
                lat_cnt++;
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            chk(1'b0, "R9", "watchdog expired", cycles, 100000);
            finish_run();
        end
    end

    // One request, compared against the model on every clock until done
    task automatic run_req(input logic [31:0] va, input string tag, input bit poke);
        logic [29:0] exp_pa;
        logic [1:0]  exp_flt;
        logic [29:0] exp_rd[$];
        int exp_k;
        int k;
        bit seen;
        model(va, exp_pa, exp_flt, exp_rd);
        exp_k = 1 + exp_rd.size() * (LAT + 1);
        @(negedge clk);
        chk(req_ready == 1'b1, tag, "ready before request", req_ready, 1);
        got_addr = {};
        req_valid = 1'b1;
        req_vaddr = va;
        seen = 1'b0;
        k = 0;
        while (!seen && k < 200) begin
            @(negedge clk);
            k++;
            req_valid = 1'b0;
            if (poke && k == 2) begin
                req_valid = 1'b1;
                req_vaddr = 32'hC000_0000;
            end
            if (done !== (k == exp_k)) begin
                chk(1'b0, "R9", "done timing", k, exp_k);
                seen = done;
            end else if (done) begin
                seen = 1'b1;
                chk(1'b1, "R9", "done timing", k, exp_k);
            end
        end
        req_valid = 1'b0;
        chk(done_paddr == exp_pa, tag, "paddr", done_paddr, exp_pa);
        chk(done_fault == exp_flt, tag, "fault", done_fault, exp_flt);
        chk(got_addr.size() == exp_rd.size(), tag, "read count", got_addr.size(), exp_rd.size());
        foreach (exp_rd[i])
            if (i < got_addr.size())
                chk(got_addr[i] == exp_rd[i], tag, "read address", got_addr[i], exp_rd[i]);
        @(negedge clk);
        chk(done == 1'b0 && req_ready == 1'b1, "R9", "single pulse then idle", done, 0);
    endtask

    initial begin
        logic [29:0] m_pa;
        logic [1:0]  m_flt;
        logic [29:0] m_rd[$];
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
        chk(done == 1'b0, "R1", "done in reset", done, 0);
        chk(mem_rd == 1'b0, "R1", "mem_rd in reset", mem_rd, 0);
        rst_n = 1'b1;

        paging_en = 1'b0;
        run_req(32'hC123_4567, "R2", 1'b0);
        run_req(32'h0000_0001, "R2", 1'b0);

        paging_en = 1'b1;
        run_req(32'hC000_0200, "R3", 1'b0);
        run_req(32'h8000_0A35, "R4", 1'b0);
        run_req(32'hBFFF_FFFF, "R4", 1'b0);
        run_req(32'h0000_0E10, "R7", 1'b0);
        run_req(32'h0000_0A04, "R9", 1'b1);
        run_req(32'h0000_1000, "R5", 1'b0);
        run_req(32'h0000_0FFF, "R5", 1'b0);
        run_req(32'h7FFF_E000, "R6", 1'b0);
        run_req(32'h7FFF_DE00, "R6", 1'b0);
        run_req(32'h7FFF_FFFF, "R6", 1'b0);

        // R8: invalid system entry
        model(32'h8000_1234, m_pa, m_flt, m_rd);
        bad_entry[int'(m_rd[0])] = 1'b1;
        run_req(32'h8000_1234, "R8", 1'b0);
        // R8: invalid second-level user entry
        model(32'h0000_0600, m_pa, m_flt, m_rd);
        bad_entry[int'(m_rd[1])] = 1'b1;
        run_req(32'h0000_0600, "R8", 1'b0);
        // R8: invalid nested system entry, no second read
        model(32'h7FFF_E000, m_pa, m_flt, m_rd);
        bad_entry[int'(m_rd[0])] = 1'b1;
        run_req(32'h7FFF_E000, "R8", 1'b0);

        finish_run();
    end
endmodule